// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address by fetching two translation words from memory. The top ten address bits pick a word in a page directory, whose location comes from a directory base register. The directory word points to a page table, and the next ten address bits pick a word in that table. The table word gives the physical frame number. The twelve low address bits pass through unchanged as the page offset. Each level holds 1024 four-byte words, so each level fills one 4 KB page.

A client hands in one linear address at a time with a valid/ready handshake. It gets back a one-cycle response that carries either the physical address or a page-fault flag. Memory reads go out on a request port with valid/ready and return one cycle or more later on a response strobe. When paging is disabled, the walker returns the linear address unchanged and makes no memory reads.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_rd_valid` is 0.
- R2: A request accepted with `paging_en` low gives a response with `resp_paddr` equal to the linear address and `resp_fault` 0. No memory read is issued.
- R3: The first read goes to address `{dir_base[31:12], 12'h000} + laddr[31:22]*4`. The low 12 bits of the base register are ignored.
- R4: The second read goes to address `{dir_word[31:12], 12'h000} + laddr[21:12]*4`, where dir_word is the data returned by the first read.
- R5: On success, `resp_paddr` is `{table_word[31:12], laddr[11:0]}` and `resp_fault` is 0. For example, a table word 00100001h for linear page 0 maps 00000ABCh to 00100ABCh.
- R6: If bit 0 (present) of the directory word is 0, the walk ends with `resp_fault` 1 and `resp_paddr` 0. No second read is made.
- R7: If bit 0 (present) of the table word is 0, the walk ends with `resp_fault` 1 and `resp_paddr` 0, after exactly two reads.
- R8: Only one request is in flight. `req_ready` is 0 from the cycle after a request is accepted until its response has been given.
- R9: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request stays asserted and its address does not change.
- R10: `resp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_laddr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Directory base register (low 12 bits ignored) |
| paging_en | input | 1 | Translation enable; low means identity mapping |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned 32-bit word |
| resp_valid | output | 1 | Translation result strobe |
| resp_paddr | output | 32 | Physical address (0 on a fault) |
| resp_fault | output | 1 | Page fault flag |

## Verification
The assertions assume three things about the memory side. It returns exactly one response strobe for each accepted read. It never returns a strobe before a read has been accepted. A new request arrives only after the previous response. The bench memory model keeps to this: it raises its strobe only in the cycle after a read handshake. The driver waits for each response before it presents the next request. A stall mode toggles `mem_rd_ready` so that the walker sees a read request held across cycles.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int AW      = 32,
    parameter int OFF_W   = 12,
    parameter int ENT_LOG = 2
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] aligned;

    always_comb begin
        aligned = {base[AW-1:OFF_W], {OFF_W{1'b0}}};
        addr    = aligned + (idx << ENT_LOG);
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int AW          = 32,
    parameter int OFF_W       = 12,
    parameter int TIDX_W      = 10,
    parameter int PRESENT_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] dir_base,
    input  logic          paging_en,
    output logic          rd_valid,
    input  logic          rd_ready,
    input  logic          rsp_valid,
    input  logic [AW-1:0] rsp_data,
    output logic [AW-1:0] cur_base,
    output logic [AW-1:0] cur_idx,
    output logic          resp_valid,
    output logic [AW-1:0] resp_paddr,
    output logic          resp_fault
);
    localparam int DIR_LO = OFF_W + TIDX_W;

    typedef struct packed {
        walk_state_e   st;
        logic [AW-1:0] laddr;
        logic [AW-1:0] base;
        logic          issued;
        logic [AW-1:0] paddr;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        req_ready  = (r_q.st == ST_IDLE);
        rd_valid   = 1'b0;
        cur_base   = r_q.base;
        cur_idx    = '0;
        resp_valid = 1'b0;
        resp_fault = 1'b0;
        resp_paddr = r_q.paddr;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.laddr  = req_laddr;
                    r_d.base   = dir_base;
                    r_d.issued = 1'b0;
                    if (paging_en) begin
                        r_d.st = ST_DIR;
                    end else begin
                        r_d.paddr = req_laddr;
                        r_d.st    = ST_DONE;
                    end
                end
            end
            ST_DIR: begin
                cur_idx  = AW'(r_q.laddr[AW-1:DIR_LO]);
                rd_valid = !r_q.issued;
                if (rd_valid && rd_ready) r_d.issued = 1'b1;
                if (r_q.issued && rsp_valid) begin
                    if (rsp_data[PRESENT_BIT]) begin
                        r_d.base   = rsp_data;
                        r_d.issued = 1'b0;
                        r_d.st     = ST_TBL;
                    end else begin
                        r_d.paddr = '0;
                        r_d.st    = ST_FAULT;
                    end
                end
            end
            ST_TBL: begin
                cur_idx  = AW'(r_q.laddr[DIR_LO-1:OFF_W]);
                rd_valid = !r_q.issued;
                if (rd_valid && rd_ready) r_d.issued = 1'b1;
                if (r_q.issued && rsp_valid) begin
                    if (rsp_data[PRESENT_BIT]) begin
                        r_d.paddr = {rsp_data[AW-1:OFF_W], r_q.laddr[OFF_W-1:0]};
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.paddr = '0;
                        r_d.st    = ST_FAULT;
                    end
                end
            end
            ST_DONE: begin
                resp_valid = 1'b1;
                r_d.st     = ST_IDLE;
            end
            ST_FAULT: begin
                resp_valid = 1'b1;
                resp_fault = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.laddr  <= '0;
            r_q.base   <= '0;
            r_q.issued <= 1'b0;
            r_q.paddr  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r6_dir_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DIR && r_q.issued && rsp_valid && !rsp_data[PRESENT_BIT])
        |=> (resp_valid && resp_fault && resp_paddr == '0));

    a_r7_tbl_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TBL && r_q.issued && rsp_valid && !rsp_data[PRESENT_BIT])
        |=> (resp_valid && resp_fault));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int AW          = 32,
    parameter int OFF_W       = 12,
    parameter int TIDX_W      = 10,
    parameter int ENT_LOG     = 2,
    parameter int PRESENT_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] dir_base,
    input  logic          paging_en,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          resp_valid,
    output logic [AW-1:0] resp_paddr,
    output logic          resp_fault
);
    logic [AW-1:0] cur_base;
    logic [AW-1:0] cur_idx;

    pt_walk_fsm #(
        .AW(AW), .OFF_W(OFF_W), .TIDX_W(TIDX_W), .PRESENT_BIT(PRESENT_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .dir_base(dir_base), .paging_en(paging_en),
        .rd_valid(mem_rd_valid), .rd_ready(mem_rd_ready),
        .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
        .cur_base(cur_base), .cur_idx(cur_idx),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    pt_entry_addr #(
        .AW(AW), .OFF_W(OFF_W), .ENT_LOG(ENT_LOG)
    ) u_addr (
        .base(cur_base), .idx(cur_idx), .addr(mem_rd_addr)
    );

    a_r9_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r2_bypass_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en)
        |=> (resp_valid && !resp_fault && !mem_rd_valid && resp_paddr == $past(req_laddr)));

    a_r3_word_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[ENT_LOG-1:0] == '0));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic [31:0] dir_base = '0;
    logic        paging_en = 1'b0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    logic [31:0] rd_log [0:3];
    logic [31:0] m_dir_addr, m_dir_word, m_tbl_addr, m_tbl_word;
    logic stall_mode = 1'b0;
    logic stall_tog = 1'b0;
    int cycles = 0;

    always #5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .dir_base(dir_base), .paging_en(paging_en),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    // memory model: answers one cycle after each accepted read
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rd_ready  <= 1'b1;
        end else begin
            if (mem_rd_valid && mem_rd_ready) begin
                if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt = rd_cnt + 1;
                mem_rsp_valid <= 1'b1;
                if (mem_rd_addr == m_dir_addr)      mem_rsp_data <= m_dir_word;
                else if (mem_rd_addr == m_tbl_addr) mem_rsp_data <= m_tbl_word;
                else                                mem_rsp_data <= 32'hDEAD_BEE0;
            end else begin
                mem_rsp_valid <= 1'b0;
            end
            stall_tog    <= ~stall_tog;
            mem_rd_ready <= stall_mode ? stall_tog : 1'b1;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic walk(input string tag, input logic [31:0] la, input logic [31:0] base,
                        input logic pg, input logic [31:0] dword, input logic [31:0] tword,
                        input logic exp_fault, input logic [31:0] exp_pa, input int exp_reads);
        int waited;
        logic [31:0] ea_dir, ea_tbl;
        ea_dir = {base[31:12], 12'h000} + {20'h0, la[31:22], 2'b00};
        ea_tbl = {dword[31:12], 12'h000} + {20'h0, la[21:12], 2'b00};
        m_dir_addr = ea_dir; m_dir_word = dword;
        m_tbl_addr = ea_tbl; m_tbl_word = tword;
        rd_cnt = 0;
        @(negedge clk);
        req_laddr = la; dir_base = base; paging_en = pg; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8", {tag, " busy"}, {31'h0, req_ready}, 32'h0);
        waited = 0;
        while (!resp_valid && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        check("R10", {tag, " response seen"}, {31'h0, resp_valid}, 32'h1);
        check(exp_fault ? "R6/R7" : (pg ? "R5" : "R2"), {tag, " paddr"}, resp_paddr, exp_pa);
        check(exp_fault ? "R6/R7" : (pg ? "R5" : "R2"), {tag, " fault"}, {31'h0, resp_fault},
              {31'h0, exp_fault});
        check(pg ? "R6" : "R2", {tag, " read count"}, rd_cnt, exp_reads);
        if (exp_reads >= 1) check("R3", {tag, " dir addr"}, rd_log[0], ea_dir);
        if (exp_reads >= 2) check("R4", {tag, " tbl addr"}, rd_log[1], ea_tbl);
        @(negedge clk);
        check("R10", {tag, " pulse ends"}, {31'h0, resp_valid}, 32'h0);
        check("R8", {tag, " ready again"}, {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_reset();
        check("R1", "req_ready", {31'h0, req_ready}, 32'h1);
        check("R1", "resp_valid", {31'h0, resp_valid}, 32'h0);
        check("R1", "mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
    endtask

    task automatic t_bypass();   // R2
        walk("bypass", 32'h1234_5678, 32'h0000_3000, 1'b0, 32'h0, 32'h0, 1'b0, 32'h1234_5678, 0);
    endtask

    task automatic t_page0();    // R3 R4 R5 example mapping
        walk("page0", 32'h0000_0ABC, 32'h0000_3000, 1'b1, 32'h0000_5001, 32'h0010_0001,
             1'b0, 32'h0010_0ABC, 2);
    endtask

    task automatic t_top_corner(); // R3 ignores low base bits, max indices
        walk("top", 32'hFFFF_FFFF, 32'hABCD_E777, 1'b1, 32'h1234_5FFF, 32'hCAFE_B003,
             1'b0, 32'hCAFE_BFFF, 2);
    endtask

    task automatic t_dir_absent(); // R6
        walk("dir_absent", 32'h0040_1123, 32'h0000_8000, 1'b1, 32'h0000_5000, 32'h0010_0001,
             1'b1, 32'h0, 1);
    endtask

    task automatic t_tbl_absent(); // R7
        walk("tbl_absent", 32'h0080_2456, 32'h0000_8000, 1'b1, 32'h0000_6001, 32'h0010_0FFE,
             1'b1, 32'h0, 2);
    endtask

    task automatic t_stall();    // R9 held request under back-pressure
        stall_mode = 1'b1;
        walk("stall", 32'h3FC0_1F0E, 32'h0002_1000, 1'b1, 32'h0007_7001, 32'h0ABC_D001,
             1'b0, 32'h0ABC_DF0E, 2);
        stall_mode = 1'b0;
    endtask

    initial begin
        m_dir_addr = '0; m_dir_word = '0; m_tbl_addr = '0; m_tbl_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_page0();
        t_top_corner();
        t_dir_absent();
        t_tbl_absent();
        t_stall();
        t_page0();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule